// File: doc/BRIEF.md
# Atomic Flow Scheduler with Per-Queue Inflight Cap

This block takes events from a small set of load-balanced source queues and hands each one to one of several consumer queues (CQs). Every event carries a source queue index, a 16-bit flow identifier and a payload. Scheduling is atomic per flow. While any event of a flow is still held by a consumer, every later event of that flow goes to the same CQ. When a consumer returns the flow's last outstanding event, the binding is dropped. The next event of that flow is then placed by round-robin over the CQs that can take it.

Each source queue has its own budget of inflight entries, taken from a configuration input. The budget is shared by all flows of that queue. A single busy flow can therefore use up the whole budget. The queue is then blocked at its head until a consumer releases something. Flow bindings live in a small associative table. Consumers give events back on a release channel that names the queue and the flow. A release that matches nothing sets a sticky error flag. The configuration must stay constant while events are inflight.

Each CQ has a one-entry output slot with a valid/ready handshake. An input event is taken only in a cycle where its target CQ slot is empty or being drained. The source queue must also have budget left.

Top module: `atomic_flow_sched`

## Requirements
- R1: After reset, every `out_valid` bit is 0 and `err_sticky` is 0.
- R2: An accepted event appears on its CQ slot at the next clock edge, with the same queue index, flow and payload. It stays valid and unchanged until the cycle in which that CQ's `out_ready` is 1.
- R3: An event whose (queue, flow) pair has at least one inflight event goes to the CQ that pair is bound to.
- R4: An event with no inflight match picks a CQ by round-robin among CQs whose slot is free, starting just after the CQ last picked this way. After reset the search starts at CQ 0.
- R5: When the number of inflight events of a queue equals its budget, `in_ready` is 0 for every event of that queue, including events of flows already bound. Other queues are unaffected. The budget of queue q is `cfg_alloc[q*8 +: 8]`.
- R6: A release of one event of a capped queue restores `in_ready` for that queue from the next cycle.
- R7: When a pair's inflight count returns to zero, its binding is cleared. Its next event is placed by the R4 round-robin.
- R8: When every flow-table entry is in use, an event with no match is refused. Events of bound pairs are still accepted. A release that frees an entry lets a new pair in.
- R9: An event of a bound pair is refused while its bound CQ slot is full and not draining, even if other CQs are free.
- R10: A release (`rel_valid`) naming a pair with no inflight events changes no count. It sets `err_sticky`, which stays 1 until reset.
- R11: The full 16-bit flow range is usable. The same flow value in two different queues forms two independent pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_alloc | input | NUM_Q*CNT_W | Inflight budget per queue, queue q at bits q*CNT_W upward |
| in_valid | input | 1 | Input event present |
| in_ready | output | 1 | Input event can be taken this cycle |
| in_qid | input | QW | Source queue index of the input event |
| in_flow | input | 16 | Flow identifier of the input event |
| in_data | input | DATA_W | Payload of the input event |
| out_valid | output | NUM_CQ | Slot of CQ c holds an event |
| out_ready | input | NUM_CQ | Consumer c takes its slot this cycle |
| out_qid | output | NUM_CQ*QW | Queue index per CQ slot |
| out_flow | output | NUM_CQ*16 | Flow per CQ slot |
| out_data | output | NUM_CQ*DATA_W | Payload per CQ slot |
| rel_valid | input | 1 | Release of one inflight event |
| rel_qid | input | QW | Queue index of the released event |
| rel_flow | input | 16 | Flow of the released event |
| err_sticky | output | 1 | Set by a release that matched no inflight pair |

## Verification
The bench fills a queue with a small budget up to its cap. It then probes both a new flow and a flow that is already bound. A design that counts per flow instead of per queue would wrongly accept the new flow. It drains a pair to zero and sends it again. A binding that survives would send the event to its old CQ instead of the round-robin pick. It stalls one consumer to show that a bound flow waits rather than spilling to a free CQ. It also fills the flow table to show that only unmatched pairs are refused. Flows 0x0000 and 0xFFFF and the same flow value in two queues catch a lookup that truncates or ignores part of the key. A bogus release must raise the error flag without opening a capped queue.

// File: rtl/afs_pkg.sv
package afs_pkg;
  localparam int FLOW_W = 16;

  // index width that never collapses to zero bits
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/afs_rr_arb.sv
module afs_rr_arb #(
  parameter  int N  = 4,
  localparam int IW = afs_pkg::idx_w(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          any,
  output logic [IW-1:0] idx
);
  // search starts one past the previous winner and wraps
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = 1; k <= N; k++) begin
      if (!any && req[(int'(last) + k) % N]) begin
        any = 1'b1;
        idx = IW'((int'(last) + k) % N);
      end
    end
  end
endmodule

// File: rtl/afs_flow_table.sv
module afs_flow_table #(
  parameter  int DEPTH = 8,
  parameter  int QW    = 1,
  parameter  int CQW   = 2,
  parameter  int CNTW  = 8,
  localparam int FW    = afs_pkg::FLOW_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [QW-1:0]  lk_q,
  input  logic [FW-1:0]  lk_flow,
  output logic           lk_hit,
  output logic [CQW-1:0] lk_cq,
  input  logic [QW-1:0]  rl_q,
  input  logic [FW-1:0]  rl_flow,
  output logic           rl_hit,
  output logic           full,
  input  logic           inc_en,
  input  logic           dec_en,
  input  logic           alloc_en,
  input  logic [CQW-1:0] alloc_cq
);
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [QW-1:0]    kq_q  [DEPTH];
  logic [QW-1:0]    kq_d  [DEPTH];
  logic [FW-1:0]    kf_q  [DEPTH];
  logic [FW-1:0]    kf_d  [DEPTH];
  logic [CQW-1:0]   cq_q  [DEPTH];
  logic [CQW-1:0]   cq_d  [DEPTH];
  logic [CNTW-1:0]  cnt_q [DEPTH];
  logic [CNTW-1:0]  cnt_d [DEPTH];
  logic [DEPTH-1:0] lk_sel, rl_sel, free_sel, ent_en;

  // two match ports plus lowest free slot
  always_comb begin
    lk_cq    = '0;
    free_sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      lk_sel[i] = vld_q[i] && (kq_q[i] == lk_q) && (kf_q[i] == lk_flow);
      rl_sel[i] = vld_q[i] && (kq_q[i] == rl_q) && (kf_q[i] == rl_flow);
      if (lk_sel[i]) lk_cq = lk_cq | cq_q[i];
    end
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_sel = DEPTH'(1) << i;
    end
    lk_hit = |lk_sel;
    rl_hit = |rl_sel;
    full   = &vld_q;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic inc_i, dec_i, al_i;
    always_comb begin
      inc_i     = inc_en && lk_sel[i];
      dec_i     = dec_en && rl_sel[i];
      al_i      = alloc_en && free_sel[i];
      ent_en[i] = inc_i || dec_i || al_i;
      kq_d[i]   = kq_q[i];
      kf_d[i]   = kf_q[i];
      cq_d[i]   = cq_q[i];
      cnt_d[i]  = cnt_q[i] + CNTW'(inc_i) - CNTW'(dec_i);
      vld_d[i]  = (cnt_d[i] != '0);
      if (al_i) begin
        kq_d[i]  = lk_q;
        kf_d[i]  = lk_flow;
        cq_d[i]  = alloc_cq;
        cnt_d[i] = CNTW'(1);
        vld_d[i] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
        cnt_q[i] <= '0;
        kq_q[i]  <= '0;
        kf_q[i]  <= '0;
        cq_q[i]  <= '0;
      end else if (ent_en[i]) begin
        vld_q[i] <= vld_d[i];
        cnt_q[i] <= cnt_d[i];
        kq_q[i]  <= kq_d[i];
        kf_q[i]  <= kf_d[i];
        cq_q[i]  <= cq_d[i];
      end
    end
  end
endmodule

// File: rtl/atomic_flow_sched.sv
module atomic_flow_sched #(
  parameter  int NUM_Q     = 2,
  parameter  int NUM_CQ    = 4,
  parameter  int TBL_DEPTH = 8,
  parameter  int CNT_W     = 8,
  parameter  int DATA_W    = 16,
  localparam int FW        = afs_pkg::FLOW_W,
  localparam int QW        = afs_pkg::idx_w(NUM_Q),
  localparam int CQW       = afs_pkg::idx_w(NUM_CQ)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_Q*CNT_W-1:0]   cfg_alloc,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [QW-1:0]            in_qid,
  input  logic [FW-1:0]            in_flow,
  input  logic [DATA_W-1:0]        in_data,
  output logic [NUM_CQ-1:0]        out_valid,
  input  logic [NUM_CQ-1:0]        out_ready,
  output logic [NUM_CQ*QW-1:0]     out_qid,
  output logic [NUM_CQ*FW-1:0]     out_flow,
  output logic [NUM_CQ*DATA_W-1:0] out_data,
  input  logic                     rel_valid,
  input  logic [QW-1:0]            rel_qid,
  input  logic [FW-1:0]            rel_flow,
  output logic                     err_sticky
);
  logic                          rst_meta_n, rst_sync_n;
  logic [NUM_Q-1:0][CNT_W-1:0]   qcnt_q, qcnt_d;
  logic [NUM_CQ-1:0]             s_vld_q, s_vld_d, s_ld;
  logic [QW-1:0]                 s_qid_q  [NUM_CQ];
  logic [FW-1:0]                 s_flow_q [NUM_CQ];
  logic [DATA_W-1:0]             s_data_q [NUM_CQ];
  logic [CQW-1:0]                rr_q, rr_d, lk_cq, gnt_idx, tgt_cq;
  logic                          err_q, err_d;
  logic                          lk_hit, rl_hit, tbl_full, gnt_any;
  logic                          q_room, accept, rel_ok, new_pick;
  logic [NUM_CQ-1:0]             cq_free;

  // reset: asserted at once, removed on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  afs_flow_table #(
    .DEPTH(TBL_DEPTH), .QW(QW), .CQW(CQW), .CNTW(CNT_W)
  ) u_tbl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .lk_q     (in_qid),
    .lk_flow  (in_flow),
    .lk_hit   (lk_hit),
    .lk_cq    (lk_cq),
    .rl_q     (rel_qid),
    .rl_flow  (rel_flow),
    .rl_hit   (rl_hit),
    .full     (tbl_full),
    .inc_en   (accept && lk_hit),
    .dec_en   (rel_ok),
    .alloc_en (new_pick),
    .alloc_cq (gnt_idx)
  );

  afs_rr_arb #(.N(NUM_CQ)) u_rr (
    .req  (cq_free),
    .last (rr_q),
    .any  (gnt_any),
    .idx  (gnt_idx)
  );

  // acceptance: budget left and a usable target slot
  always_comb begin
    cq_free  = ~s_vld_q | out_ready;
    q_room   = qcnt_q[in_qid] < cfg_alloc[int'(in_qid)*CNT_W +: CNT_W];
    in_ready = q_room && (lk_hit ? cq_free[lk_cq] : (!tbl_full && gnt_any));
    tgt_cq   = lk_hit ? lk_cq : gnt_idx;
    accept   = in_valid && in_ready;
    new_pick = accept && !lk_hit;
    rel_ok   = rel_valid && rl_hit;
  end

  // next state
  always_comb begin
    for (int q = 0; q < NUM_Q; q++) begin
      qcnt_d[q] = qcnt_q[q]
                + CNT_W'(accept && (in_qid == QW'(q)))
                - CNT_W'(rel_ok && (rel_qid == QW'(q)));
    end
    for (int c = 0; c < NUM_CQ; c++) begin
      s_ld[c]    = accept && (tgt_cq == CQW'(c));
      s_vld_d[c] = s_ld[c] || (s_vld_q[c] && !out_ready[c]);
    end
    rr_d  = new_pick ? gnt_idx : rr_q;
    err_d = err_q || (rel_valid && !rl_hit);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      qcnt_q  <= '0;
      s_vld_q <= '0;
      rr_q    <= CQW'(NUM_CQ - 1);
      err_q   <= 1'b0;
    end else begin
      if (accept || rel_ok) qcnt_q <= qcnt_d;
      s_vld_q <= s_vld_d;
      if (new_pick) rr_q <= rr_d;
      if (rel_valid) err_q <= err_d;
    end
  end

  for (genvar c = 0; c < NUM_CQ; c++) begin : g_slot
    always_ff @(posedge clk) begin
      if (s_ld[c]) begin
        s_qid_q[c]  <= in_qid;
        s_flow_q[c] <= in_flow;
        s_data_q[c] <= in_data;
      end
    end
    assign out_qid[c*QW +: QW]         = s_qid_q[c];
    assign out_flow[c*FW +: FW]        = s_flow_q[c];
    assign out_data[c*DATA_W +: DATA_W] = s_data_q[c];
  end

  assign out_valid  = s_vld_q;
  assign err_sticky = err_q;
endmodule

// File: rtl/atomic_flow_sched_chk.sv
module atomic_flow_sched_chk #(
  parameter int NUM_Q  = 2,
  parameter int NUM_CQ = 4,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid,
  input logic                         in_ready,
  input logic [NUM_CQ-1:0]            out_valid,
  input logic [NUM_CQ-1:0]            out_ready,
  input logic [NUM_CQ*DATA_W-1:0]     out_data,
  input logic                         rel_valid,
  input logic                         rl_hit,
  input logic                         lk_hit,
  input logic                         tbl_full,
  input logic                         err_sticky,
  input logic [NUM_Q-1:0][CNT_W-1:0]  qcnt,
  input logic [NUM_Q*CNT_W-1:0]       cfg_alloc
);
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> |out_valid);

  a_r8_table_full: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_full && !lk_hit |-> !in_ready);

  a_r10_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid && !rl_hit |=> err_sticky);

  a_r10_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  for (genvar c = 0; c < NUM_CQ; c++) begin : g_cq
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[c] && !out_ready[c] |=>
        out_valid[c] && $stable(out_data[c*DATA_W +: DATA_W]));
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    a_r5_within_budget: assert property (@(posedge clk) disable iff (!rst_n)
      qcnt[q] <= cfg_alloc[q*CNT_W +: CNT_W]);
  end
endmodule

bind atomic_flow_sched atomic_flow_sched_chk #(
  .NUM_Q(NUM_Q), .NUM_CQ(NUM_CQ), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .rel_valid  (rel_valid),
  .rl_hit     (rl_hit),
  .lk_hit     (lk_hit),
  .tbl_full   (tbl_full),
  .err_sticky (err_sticky),
  .qcnt       (qcnt_q),
  .cfg_alloc  (cfg_alloc)
);

// File: tb/atomic_flow_sched_test.sv
module atomic_flow_sched_test;
  localparam int NQ  = 2;
  localparam int NCQ = 4;
  localparam int CW  = 8;
  localparam int DW  = 16;
  localparam int QW  = 1;

  logic               clk, rst_n;
  logic [NQ*CW-1:0]   cfg_alloc;
  logic               in_valid, in_ready;
  logic [QW-1:0]      in_qid;
  logic [15:0]        in_flow;
  logic [DW-1:0]      in_data;
  logic [NCQ-1:0]     out_valid, out_ready;
  logic [NCQ*QW-1:0]  out_qid;
  logic [NCQ*16-1:0]  out_flow;
  logic [NCQ*DW-1:0]  out_data;
  logic               rel_valid;
  logic [QW-1:0]      rel_qid;
  logic [15:0]        rel_flow;
  logic               err_sticky;

  int checks = 0;
  int errors = 0;
  logic [39:0] expq [NCQ][$];
  string       tagq [NCQ][$];

  atomic_flow_sched uut (
    .clk(clk), .rst_n(rst_n), .cfg_alloc(cfg_alloc),
    .in_valid(in_valid), .in_ready(in_ready), .in_qid(in_qid),
    .in_flow(in_flow), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_qid(out_qid),
    .out_flow(out_flow), .out_data(out_data),
    .rel_valid(rel_valid), .rel_qid(rel_qid), .rel_flow(rel_flow),
    .err_sticky(err_sticky)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a slot is consumed
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCQ; c++) begin
        if (out_valid[c] && out_ready[c]) begin
          logic [39:0] got;
          got = {7'd0, out_qid[c*QW +: QW], out_flow[c*16 +: 16], out_data[c*DW +: DW]};
          if (expq[c].size() == 0) begin
            check_eq($sformatf("R2 unexpected event on CQ%0d", c), {24'd0, got}, 64'd0);
          end else begin
            check_eq($sformatf("R2 %s on CQ%0d", tagq[c][0], c), {24'd0, got}, {24'd0, expq[c][0]});
            void'(expq[c].pop_front());
            void'(tagq[c].pop_front());
          end
        end
      end
    end
  end

  task automatic send(input int q, input int f, input int d, input int cq, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_qid = QW'(q); in_flow = 16'(f); in_data = DW'(d);
    #1;
    check_eq({tag, " in_ready"}, {63'd0, in_ready}, 64'd1);
    if (in_ready) begin
      expq[cq].push_back({8'(q), 16'(f), 16'(d)});
      tagq[cq].push_back(tag);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic probe(input int q, input int f, input logic exp, input string tag);
    @(negedge clk);
    in_valid = 1'b0; in_qid = QW'(q); in_flow = 16'(f);
    #1;
    check_eq(tag, {63'd0, in_ready}, {63'd0, exp});
  endtask

  task automatic release_ev(input int q, input int f);
    @(negedge clk);
    rel_valid = 1'b1; rel_qid = QW'(q); rel_flow = 16'(f);
    @(posedge clk); #1;
    rel_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_qid = '0; in_flow = '0; in_data = '0;
    rel_valid = 1'b0; rel_qid = '0; rel_flow = '0; out_ready = '1;
    cfg_alloc = {8'd3, 8'd16};   // queue1 budget 3, queue0 budget 16
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_eq("R1 out_valid after reset", {60'd0, out_valid}, 64'd0);
    check_eq("R1 err_sticky after reset", {63'd0, err_sticky}, 64'd0);

    // R4 round robin from CQ0, R11 extreme flow values and queue separation
    send(0, 16'h0000, 16'h0001, 0, "R4 first new flow");
    send(0, 16'hFFFF, 16'h0002, 1, "R11 flow FFFF");
    send(1, 16'h0000, 16'h0003, 2, "R11 same flow other queue");
    send(0, 16'h0000, 16'h0004, 0, "R3 bound flow");
    send(1, 16'h0005, 16'h0005, 3, "R4 new flow q1");
    send(1, 16'h0005, 16'h0006, 3, "R3 bound back to back");

    // R5 queue1 at its budget of 3
    probe(1, 16'h0009, 1'b0, "R5 new flow at cap");
    probe(1, 16'h0005, 1'b0, "R5 bound flow at cap");
    probe(0, 16'h0007, 1'b1, "R5 other queue open");

    // R6 / R7
    release_ev(1, 16'h0000);
    probe(1, 16'h0009, 1'b1, "R6 room after release");
    send(1, 16'h0000, 16'h0007, 0, "R7 unbound flow rescheduled");

    // R10 bogus release
    release_ev(1, 16'h1234);
    @(negedge clk);
    check_eq("R10 err_sticky set", {63'd0, err_sticky}, 64'd1);
    probe(1, 16'h0009, 1'b0, "R10 bogus release kept cap");

    // R9 bound CQ stalled
    @(posedge clk); #1 out_ready[1] = 1'b0;
    send(0, 16'hFFFF, 16'h0099, 1, "R9 bound to stalled CQ1");
    probe(0, 16'hFFFF, 1'b0, "R9 bound flow waits");
    check_eq("R2 slot held", {63'd0, out_valid[1]}, 64'd1);
    probe(0, 16'h0077, 1'b1, "R9 new flow may use free CQ");
    check_eq("R2 data stable", {48'd0, out_data[DW +: DW]}, 64'h99);
    @(posedge clk); #1 out_ready[1] = 1'b1;

    // R8 fill the table (4 used, 4 more)
    send(0, 16'h0100, 16'h0010, 1, "R8 fill 1");
    send(0, 16'h0101, 16'h0011, 2, "R8 fill 2");
    send(0, 16'h0102, 16'h0012, 3, "R8 fill 3");
    send(0, 16'h0103, 16'h0013, 0, "R8 fill 4");
    probe(0, 16'h0200, 1'b0, "R8 new flow refused when full");
    probe(0, 16'h0000, 1'b1, "R8 bound flow accepted when full");
    release_ev(0, 16'h0100);
    probe(0, 16'h0200, 1'b1, "R8 entry freed");
    send(0, 16'h0200, 16'h0020, 1, "R8 new flow after free");

    // R3 partial release keeps binding, R7 full drain clears it
    release_ev(0, 16'h0000);
    send(0, 16'h0000, 16'h0030, 0, "R3 still bound after partial release");
    release_ev(0, 16'h0000);
    release_ev(0, 16'h0000);
    send(0, 16'h0000, 16'h0031, 2, "R7 rebind by round robin");

    repeat (4) @(negedge clk);
    check_eq("R10 err_sticky holds", {63'd0, err_sticky}, 64'd1);
    for (int c = 0; c < NCQ; c++)
      check_eq($sformatf("R2 CQ%0d scoreboard drained", c), 64'(expq[c].size()), 64'd0);
    finish_run();
  end
endmodule